// File: doc/BRIEF.md
# Serial Byte Store-and-Forward Controller

This block sits between a byte receiver, an internal 8-bit synchronous FIFO and a byte transmitter. On the receive side, the receiver raises a level-style new-byte flag and holds it. The controller takes the byte exactly once, writes it into the FIFO with a single-cycle write pulse and acknowledges the receiver. The acknowledge stays high until the receiver drops its flag. Because a byte is only taken while the FIFO has room, a receiver facing a full FIFO waits, and nothing is lost.

The transmit side is gated by a start request, for example a debounced button event. Each start request moves the transmit machine from idle to a sending state. There it waits until the FIFO holds a byte and the transmitter's done line is low. It then pops the head entry with a single-cycle read, presents the byte and raises ready. When the transmitter reports done, ready falls and the machine returns to idle. Each start request therefore forwards at most one byte. The bytes leave in the order they arrived.

The receive machine has two states, RX_WAIT and RX_HELD. It takes a byte on RX_WAIT to RX_HELD and releases the flag on RX_HELD to RX_WAIT. The transmit machine has three states, TX_IDLE, TX_ARM and TX_BUSY. A start request moves it from TX_IDLE to TX_ARM. A pop moves it from TX_ARM to TX_BUSY. Done moves it from TX_BUSY back to TX_IDLE.

Top module: `byte_relay_ctrl`

## Requirements
- R1: While rst is high, and on the first cycle after it falls, rx_ack and tx_ready are low, the FIFO is empty and both machines are idle. A reset during a pending send cancels that send.
- R2: When rx_valid is high, the FIFO holds fewer than DEPTH entries and no byte is currently acknowledged, the byte on rx_data is stored, and rx_ack is high one clock edge after rx_valid was first sampled high.
- R3: Each received byte produces exactly one FIFO write of one cycle, however many cycles rx_valid is held high.
- R4: rx_ack stays high while rx_valid stays high, and it is low one clock edge after rx_valid is sampled low.
- R5: When the FIFO holds DEPTH entries (28 by default), rx_valid is not acknowledged and no write occurs. The byte is taken once a pop frees an entry.
- R6: The transmit side does nothing until a start_req pulse arrives. With the FIFO non-empty and tx_done low, tx_ready is high two clock edges after start_req is sampled. After one byte completes, tx_ready stays low until the next start_req.
- R7: After a start_req, when the FIFO is empty, the transmit side waits in its sending state. tx_ready rises once a byte has been stored.
- R8: While tx_ready is high and tx_done is low, tx_ready stays high and tx_data stays stable. When tx_done is sampled high with tx_ready, tx_ready is low one clock edge later.
- R9: A start_req that arrives while a byte is being handed over (tx_ready high) has no effect, so no second byte follows without a new start_req.
- R10: Bytes are forwarded in arrival order. Each handshake pops exactly one entry with a one-cycle read, so no byte is lost or duplicated at the full depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| rx_valid | input | 1 | Receiver new-byte flag, held until acknowledged |
| rx_data | input | DATA_W | Byte from the receiver |
| rx_ack | output | 1 | Byte taken; falls after rx_valid falls |
| start_req | input | 1 | One-cycle request to forward one byte |
| tx_done | input | 1 | Transmitter has finished the presented byte |
| tx_ready | output | 1 | tx_data holds a byte for the transmitter |
| tx_data | output | DATA_W | Byte presented to the transmitter |

## Verification
The assertions assume the receiver holds rx_valid and rx_data steady from rise until it sees rx_ack, and lowers rx_valid before offering the next byte. They also assume the transmitter raises tx_done only while tx_ready is high, and lowers it once tx_ready has fallen. The bench keeps to these rules. Its receiver task drives rx_valid at falling edges and waits for the acknowledge before releasing the flag. Its transmitter process answers each tx_ready with a done that lasts exactly until tx_ready drops. Start requests are single-cycle pulses, and they are placed deliberately in idle, in the waiting state and during a pending handshake.

// File: rtl/byte_relay_pkg.sv
package byte_relay_pkg;
    typedef enum logic {
        RX_WAIT,
        RX_HELD
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_ARM,
        TX_BUSY
    } tx_state_t;
endpackage

// File: rtl/relay_fifo.sv
module relay_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_wr, do_rd;

    assign full    = (count == CAP);
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/relay_ingest.sv
module relay_ingest (
    input  logic clk,
    input  logic rst,
    input  logic rx_valid,
    input  logic fifo_full,
    output logic wr_en,
    output logic rx_ack
);
    import byte_relay_pkg::*;

    rx_state_t state, nxt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= RX_WAIT;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt    = state;
        wr_en  = 1'b0;
        rx_ack = 1'b0;
        unique case (state)
            RX_WAIT: begin
                if (rx_valid && !fifo_full) begin
                    wr_en = 1'b1;
                    nxt   = RX_HELD;
                end
            end
            RX_HELD: begin
                rx_ack = 1'b1;
                if (!rx_valid) begin
                    nxt = RX_WAIT;
                end
            end
            default: nxt = RX_WAIT;
        endcase
    end
endmodule

// File: rtl/relay_egress.sv
module relay_egress #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              tx_done,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] head,
    output logic              rd_en,
    output logic              tx_ready,
    output logic [DATA_W-1:0] tx_data
);
    import byte_relay_pkg::*;

    tx_state_t state, nxt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state   <= TX_IDLE;
            tx_data <= '0;
        end else begin
            state <= nxt;
            if (rd_en) begin
                tx_data <= head;
            end
        end
    end

    always_comb begin
        nxt      = state;
        rd_en    = 1'b0;
        tx_ready = 1'b0;
        unique case (state)
            TX_IDLE: begin
                if (start_req) begin
                    nxt = TX_ARM;
                end
            end
            TX_ARM: begin
                if (!fifo_empty && !tx_done) begin
                    rd_en = 1'b1;
                    nxt   = TX_BUSY;
                end
            end
            TX_BUSY: begin
                tx_ready = 1'b1;
                if (tx_done) begin
                    nxt = TX_IDLE;
                end
            end
            default: nxt = TX_IDLE;
        endcase
    end
endmodule

// File: rtl/byte_relay_ctrl.sv
module byte_relay_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ack,
    input  logic              start_req,
    input  logic              tx_done,
    output logic              tx_ready,
    output logic [DATA_W-1:0] tx_data
);
    logic              wr_en, rd_en;
    logic              fifo_full, fifo_empty;
    logic [DATA_W-1:0] head;

    relay_ingest u_ingest (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .fifo_full (fifo_full),
        .wr_en     (wr_en),
        .rx_ack    (rx_ack)
    );

    relay_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (rx_data),
        .rd_en   (rd_en),
        .rd_data (head),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    relay_egress #(
        .DATA_W (DATA_W)
    ) u_egress (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .tx_done    (tx_done),
        .fifo_empty (fifo_empty),
        .head       (head),
        .rd_en      (rd_en),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data)
    );
endmodule

// File: rtl/byte_relay_chk.sv
module byte_relay_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              rx_ack,
    input logic              tx_ready,
    input logic              tx_done,
    input logic [DATA_W-1:0] tx_data,
    input logic              wr_en,
    input logic              rd_en,
    input logic              fifo_full,
    input logic              fifo_empty
);
    AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rx_ack);                                       // R2
    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);                                       // R3
    AST_NO_WRITE_WHILE_ACKED: assert property (@(posedge clk) disable iff (rst)
        rx_ack |-> !wr_en);                                      // R3
    AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rx_ack && rx_valid) |=> rx_ack);                        // R4
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rx_ack && !rx_valid) |=> !rx_ack);                      // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !wr_en);                                   // R5
    AST_READY_STABLE: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !tx_done) |=> (tx_ready && $stable(tx_data))); // R8
    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && tx_done) |=> !tx_ready);                    // R8
    AST_NO_POP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !rd_en);                                    // R9
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (!rd_en && tx_ready));                         // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> !rd_en);                                  // R10
endmodule

bind byte_relay_ctrl byte_relay_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_ack     (rx_ack),
    .tx_ready   (tx_ready),
    .tx_done    (tx_done),
    .tx_data    (tx_data),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty)
);

// File: tb/byte_relay_ctrl_tb.sv
module byte_relay_ctrl_tb;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 28;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_valid = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              rx_ack;
    logic              start_req = 1'b0;
    logic              tx_done = 1'b0;
    logic              tx_ready;
    logic [DATA_W-1:0] tx_data;

    int checks = 0;
    int fails  = 0;
    int out_count = 0;
    int done_delay = 0;
    logic [DATA_W-1:0] expq[$];

    always #10 clk = ~clk;

    byte_relay_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ack    (rx_ack),
        .start_req (start_req),
        .tx_done   (tx_done),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // receiver model: offer one byte and hold the flag hold extra cycles
    task automatic send_byte(input logic [DATA_W-1:0] b, input int hold);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        chk(rx_ack === 1'b1, "R2", "ack one edge after flag", int'(rx_ack), 1);
        expq.push_back(b);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(rx_ack === 1'b1, "R4", "ack held with flag", int'(rx_ack), 1);
        end
        rx_valid = 1'b0;
        @(negedge clk);
        chk(rx_ack === 1'b0, "R4", "ack released", int'(rx_ack), 0);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic wait_out(input int target, input string req);
        int n = 0;
        while (out_count < target && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(out_count == target, req, "bytes forwarded", out_count, target);
    endtask

    task automatic idle_ready(input int cycles, input string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tx_ready) seen++;
        end
        chk(seen == 0, req, "tx_ready stays low", seen, 0);
    endtask

    // transmitter model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (tx_ready === 1'b1 && !rst) begin
                logic [DATA_W-1:0] first;
                first = tx_data;
                if (expq.size() == 0) begin
                    chk(1'b0, "R10", "unexpected byte", int'(tx_data), -1);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = expq.pop_front();
                    chk(tx_data == e, "R10", "byte order", int'(tx_data), int'(e));
                end
                for (int i = 0; i < done_delay; i++) begin
                    @(negedge clk);
                    chk(tx_ready === 1'b1 && tx_data == first, "R8",
                        "ready and data held", int'(tx_data), int'(first));
                end
                tx_done = 1'b1;
                @(negedge clk);
                chk(tx_ready === 1'b0, "R8", "ready drop after done", int'(tx_ready), 0);
                tx_done = 1'b0;
                out_count++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(rx_ack === 1'b0, "R1", "ack in reset", int'(rx_ack), 0);
        chk(tx_ready === 1'b0, "R1", "ready in reset", int'(tx_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_ack === 1'b0 && tx_ready === 1'b0, "R1", "outputs after reset",
            int'(rx_ack) + int'(tx_ready), 0);

        // R7 start with empty FIFO waits, then forwards the first byte
        pulse_start();
        idle_ready(5, "R7");
        send_byte(8'hA5, 0);
        wait_out(1, "R7");

        // R3 several bytes, some with long held flags
        send_byte(8'h11, 0);
        send_byte(8'h22, 6);
        send_byte(8'h33, 1);
        send_byte(8'h44, 9);
        // R6 nothing leaves without a start request
        idle_ready(6, "R6");
        pulse_start();
        @(negedge clk);
        chk(tx_ready === 1'b1, "R6", "ready two edges after start", int'(tx_ready), 1);
        wait_out(2, "R6");
        idle_ready(5, "R6");
        pulse_start();
        wait_out(3, "R3");

        // R9 start during a pending handshake is ignored
        done_delay = 6;
        pulse_start();
        repeat (2) @(negedge clk);
        pulse_start();
        wait_out(4, "R9");
        done_delay = 0;
        idle_ready(6, "R9");
        pulse_start();
        wait_out(5, "R3");
        chk(expq.size() == 0, "R3", "no duplicate entries", expq.size(), 0);

        // R5 fill to DEPTH, then offer one more
        for (int i = 0; i < DEPTH; i++) begin
            send_byte(DATA_W'(8'h80 + i), i % 3);
        end
        @(negedge clk);
        rx_data  = 8'h5C;
        rx_valid = 1'b1;
        begin
            int acks = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (rx_ack) acks++;
            end
            chk(acks == 0, "R5", "no ack while full", acks, 0);
        end
        pulse_start();
        begin
            int n = 0;
            while (!rx_ack && n < 10) begin
                @(negedge clk);
                n++;
            end
            chk(rx_ack === 1'b1, "R5", "taken after pop", int'(rx_ack), 1);
        end
        expq.push_back(8'h5C);
        rx_valid = 1'b0;
        wait_out(6, "R5");
        for (int i = 0; i < DEPTH; i++) begin
            pulse_start();
            wait_out(7 + i, "R10");
        end
        chk(expq.size() == 0, "R10", "all bytes forwarded", expq.size(), 0);

        // R1 reset cancels a pending send
        pulse_start();
        idle_ready(3, "R7");
        rst = 1'b1;
        @(negedge clk);
        chk(tx_ready === 1'b0 && rx_ack === 1'b0, "R1", "outputs in mid reset",
            int'(tx_ready), 0);
        rst = 1'b0;
        send_byte(8'h3C, 0);
        idle_ready(6, "R1");
        pulse_start();
        wait_out(DEPTH + 7, "R1");

        summary();
        $finish;
    end
endmodule